// File: doc/BRIEF.md
# Motion Threshold Interrupt Engine

This block watches a stream of three-axis signed acceleration samples and raises an interrupt when motion, or the lack of it, crosses a programmable 16-bit level. For each sample, every axis is compared as a two's-complement number against the level. The comparison produces an "above" event and a "below" event for that axis. Software enables any subset of the six events. It then chooses whether the enabled events are merged by OR, which catches motion past the level on any axis, or by AND, which catches a free-fall style condition that all enabled axes must meet together.

The merged condition must hold for a programmable number of consecutive samples before it counts. The block can also hold a captured event until software clears it with a read of a dedicated clear address. Configuration, level, duration and the event source are reached through a small byte-wide register port with a write strobe and a read strobe. Read data is presented combinationally for the current address.

Top module: `motion_event_engine`

## Requirements
- R1: After reset, the config register (address 0), both threshold bytes (addresses 3 and 4), the duration register (address 5) and the source register (address 1) read 0, and `irq_o` is low.
- R2: A write to address 0, 3, 4 or 5 stores `reg_wdata`, and a read of that address returns it. The source (address 1) and clear (address 2) addresses ignore writes. A read of address 2 always returns 0.
- R3: Config bit layout: bit 7 selects AND (1) or OR (0), bit 6 requests latching, and bits 5..0 enable Z-above, Z-below, Y-above, Y-below, X-above and X-below. Source layout: bit 6 is interrupt-active, bits 5..0 use the same event order, and bit 7 reads 0.
- R4: Using signed 16-bit arithmetic with threshold = {addr4, addr3}, an axis has an "above" event when its sample is greater than the threshold and a "below" event when it is less. An equal sample gives neither event.
- R5: In OR mode, the condition is true when at least one enabled event is present.
- R6: In AND mode, the condition is true only when every enabled event is present. Disabled events do not take part. With no event enabled, the condition is never true in either mode.
- R7: With duration D, a sample qualifies when the condition is true on it and on the D samples before it. D = 0 qualifies on the first true sample, and a false sample restarts the count.
- R8: With latching off, every sample loads the source register. The load sets interrupt-active to the qualified result and sets bits 5..0 to the enabled events present when qualified, or 0 otherwise. `irq_o` equals source bit 6.
- R9: With latching on, once interrupt-active has been loaded as 1, later samples leave the source register and `irq_o` unchanged until address 2 is read.
- R10: After a read of address 2, the next sample loads the source register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_x | input | 16 | X axis sample, two's complement |
| smp_y | input | 16 | Y axis sample, two's complement |
| smp_z | input | 16 | Z axis sample, two's complement |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; only has an effect at address 2 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt output |

## Verification
A wrong duration count shows up as `irq_o` rising one or more samples early or late after a run of true conditions. A count that fails to clear shows up as a fire straight after a broken run. Both appear on the very sample the result is due, so the source and interrupt are compared after every sample. A stuck hold state shows up as a source register that never refreshes after the clear read, or one that changes while it should be frozen. This is visible on the first sample after the clear read, or on the first sample after the hold begins. Incorrect signed handling shows up when the threshold is negative, or when samples sit one step either side of it. Random samples are therefore drawn around the threshold as well as over the full range.

// File: rtl/mee_pkg.sv
package mee_pkg;
  localparam int REG_AW = 3;
  localparam int NUM_AXES = 3;
  localparam int NUM_EV = 2 * NUM_AXES;

  typedef enum logic [REG_AW-1:0] {
    RA_CFG = 3'd0,
    RA_SRC = 3'd1,
    RA_CLR = 3'd2,
    RA_THL = 3'd3,
    RA_THH = 3'd4,
    RA_DUR = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/mee_compare.sv
module mee_compare #(
  parameter int DATA_W = 16,
  parameter int AXES = 3
) (
  input  logic [AXES-1:0][DATA_W-1:0] axis_val,
  input  logic [DATA_W-1:0]           thr,
  output logic [2*AXES-1:0]           events
);
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic above, below;
    always_comb begin
      above = $signed(axis_val[a]) > $signed(thr);
      below = $signed(axis_val[a]) < $signed(thr);
      a_r4_not_both: assert (!(above && below));
    end
    assign events[2*a]   = below;
    assign events[2*a+1] = above;
  end
endmodule

// File: rtl/mee_combine.sv
module mee_combine #(
  parameter int NEV = 6
) (
  input  logic [NEV-1:0] events,
  input  logic [NEV-1:0] enables,
  input  logic           and_mode,
  output logic [NEV-1:0] masked,
  output logic           cond
);
  logic any_en;
  always_comb begin
    masked = events & enables;
    any_en = |enables;
    if (!any_en)       cond = 1'b0;
    else if (and_mode) cond = (masked == enables);
    else               cond = |masked;
  end
endmodule

// File: rtl/mee_duration.sv
module mee_duration #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             cond,
  input  logic [DUR_W-1:0] dur,
  output logic             qual
);
  logic [DUR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    qual  = cond && (cnt_q >= dur);
    cnt_d = cnt_q;
    if (step) begin
      if (!cond)           cnt_d = '0;
      else if (cnt_q < dur) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  a_r7_false_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cond) |=> (cnt_q == '0));
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (cnt_q <= dur)) |=> (cnt_q <= $past(dur)));
endmodule

// File: rtl/motion_event_engine.sv
module motion_event_engine
  import mee_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DUR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_x,
  input  logic [DATA_W-1:0] smp_y,
  input  logic [DATA_W-1:0] smp_z,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);
  localparam int SRC_W = NUM_EV + 1;

  logic [7:0]         cfg_q, thl_q, thh_q;
  logic [DUR_W-1:0]   dur_q;
  logic [SRC_W-1:0]   src_q, src_d;
  logic               hold_q, hold_d;
  logic [NUM_EV-1:0]  events, masked;
  logic               cond, qual, clr_rd, src_load;
  logic [NUM_AXES-1:0][DATA_W-1:0] axes;
  logic [DATA_W-1:0]  thr;

  assign axes = {smp_z, smp_y, smp_x};
  assign thr  = DATA_W'({thh_q, thl_q});

  mee_compare #(.DATA_W(DATA_W), .AXES(NUM_AXES)) u_cmp (
    .axis_val(axes), .thr(thr), .events(events));

  mee_combine #(.NEV(NUM_EV)) u_comb (
    .events(events), .enables(cfg_q[NUM_EV-1:0]), .and_mode(cfg_q[7]),
    .masked(masked), .cond(cond));

  mee_duration #(.DUR_W(DUR_W)) u_dur (
    .clk(clk), .rst_n(rst_n), .step(smp_valid), .cond(cond),
    .dur(dur_q), .qual(qual));

  always_comb begin
    clr_rd   = reg_rd && (reg_addr == RA_CLR);
    src_load = smp_valid && !(cfg_q[6] && hold_q);
    src_d    = src_q;
    if (src_load) src_d = {qual, (qual ? masked : {NUM_EV{1'b0}})};
    hold_d = hold_q;
    if (clr_rd)                hold_d = 1'b0;
    else if (!cfg_q[6])        hold_d = 1'b0;
    else if (src_load && qual) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      thl_q <= '0;
      thh_q <= '0;
      dur_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == RA_CFG) cfg_q <= reg_wdata;
      if (reg_addr == RA_THL) thl_q <= reg_wdata;
      if (reg_addr == RA_THH) thh_q <= reg_wdata;
      if (reg_addr == RA_DUR) dur_q <= DUR_W'(reg_wdata);
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CFG:  reg_rdata = cfg_q;
      RA_SRC:  reg_rdata = 8'(src_q);
      RA_THL:  reg_rdata = thl_q;
      RA_THH:  reg_rdata = thh_q;
      RA_DUR:  reg_rdata = 8'(dur_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_o = src_q[NUM_EV];

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && cfg_q[6]) |=> $stable(src_q));
  a_r10_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> !hold_q);
  a_r6_none_enabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_load && (cfg_q[NUM_EV-1:0] == '0)) |=> !irq_o);
  a_r8_flags_need_active: assert property (@(posedge clk) disable iff (!rst_n)
    !src_q[NUM_EV] |-> (src_q[NUM_EV-1:0] == '0));
endmodule

// File: tb/sim_motion_event_engine.sv
`timescale 1ns/1ps
module sim_motion_event_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_cfg, m_thl, m_thh, m_dur;
  logic [6:0] m_src;
  logic       m_hold;
  int         m_cnt;

  always #2 clk = ~clk;

  motion_event_engine u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  function automatic logic [5:0] ev_of(logic signed [15:0] x, logic signed [15:0] y,
                                       logic signed [15:0] z, logic signed [15:0] t);
    return {z > t, z < t, y > t, y < t, x > t, x < t};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      3'd0: m_cfg = d;
      3'd3: m_thl = d;
      3'd4: m_thh = d;
      3'd5: m_dur = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clr(string req);
    @(negedge clk);
    reg_addr = 3'd2; reg_rd = 1'b1;
    #1 check(req, reg_rdata, 0);
    @(negedge clk);
    reg_rd = 1'b0;
    m_hold = 1'b0;
  endtask

  task automatic smp(string req, logic [15:0] x, logic [15:0] y, logic [15:0] z);
    logic [5:0] ev, en, mk;
    logic cond, qual;
    logic [7:0] d;
    @(negedge clk);
    smp_x = x; smp_y = y; smp_z = z; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    en = m_cfg[5:0];
    ev = ev_of(x, y, z, {m_thh, m_thl});
    mk = ev & en;
    cond = (en != 0) && (m_cfg[7] ? (mk == en) : (mk != 0));
    qual = cond && (m_cnt >= int'(m_dur));
    if (!cond) m_cnt = 0;
    else if (m_cnt < int'(m_dur)) m_cnt++;
    if (!(m_cfg[6] && m_hold)) begin
      m_src = {qual, qual ? mk : 6'd0};
      if (m_cfg[6] && qual) m_hold = 1'b1;
    end
    if (!m_cfg[6]) m_hold = 1'b0;
    check(req, irq_o, m_src[6]);
    rd(3'd1, d);
    check(req, d, {1'b0, m_src});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    m_cfg = 0; m_thl = 0; m_thh = 0; m_dur = 0; m_src = 0; m_hold = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1 irq", irq_o, 0);
    foreach (m_src[i]) begin end
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reset read", d, 0);
    end
    // R2 readback and ignored writes
    wr(3'd0, 8'hA5); rd(3'd0, d); check("R2 cfg", d, 8'hA5);
    wr(3'd3, 8'h3C); rd(3'd3, d); check("R2 thl", d, 8'h3C);
    wr(3'd4, 8'hC3); rd(3'd4, d); check("R2 thh", d, 8'hC3);
    wr(3'd5, 8'h7E); rd(3'd5, d); check("R2 dur", d, 8'h7E);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R2 src ignores write", d, 0);
    wr(3'd2, 8'hFF); rd(3'd2, d); check("R2 clear reads zero", d, 0);
    // R4 signed compare, threshold -5, OR mode with X events (R3 bits 1,0)
    wr(3'd5, 8'd0);
    wr(3'd3, 8'hFB); wr(3'd4, 8'hFF);
    wr(3'd0, 8'h03);
    smp("R4 above negative thr", 16'd3, 16'd0, 16'd0);
    smp("R4 below", 16'hFF9C, 16'd0, 16'd0);
    smp("R4 equal gives none", 16'hFFFB, 16'd0, 16'd0);
    smp("R4 one above", 16'hFFFC, 16'd0, 16'd0);
    // R5 OR mode on Y-above and X-above
    wr(3'd3, 8'd100); wr(3'd4, 8'd0);
    wr(3'd0, 8'h0A);
    smp("R5 only Y above", 16'd0, 16'd200, 16'd0);
    smp("R5 none", 16'd0, 16'd0, 16'd0);
    // R6 AND mode
    wr(3'd0, 8'h8A);
    smp("R6 only X above", 16'd200, 16'd0, 16'd0);
    smp("R6 X and Y above", 16'd200, 16'd300, 16'd300);
    wr(3'd0, 8'h80);
    smp("R6 no enables AND", 16'd200, 16'd300, 16'd300);
    wr(3'd0, 8'h00);
    smp("R6 no enables OR", 16'hFFFF, 16'd300, 16'd300);
    // R7 duration 2
    wr(3'd0, 8'h20); wr(3'd5, 8'd2);
    smp("R7 first", 0, 0, 16'd500);
    smp("R7 second", 0, 0, 16'd500);
    smp("R7 third fires", 0, 0, 16'd500);
    smp("R7 break", 0, 0, 16'd0);
    smp("R7 restart", 0, 0, 16'd500);
    // R8 non-latched follows samples
    wr(3'd5, 8'd0);
    smp("R8 event", 0, 0, 16'd500);
    smp("R8 clears", 0, 0, 16'd0);
    // R9 latch, R10 release
    wr(3'd0, 8'h60);
    smp("R9 latched event", 0, 0, 16'd500);
    smp("R9 held", 0, 0, 16'd0);
    smp("R9 still held", 0, 16'd0, 16'd1);
    clr("R10 clear read");
    smp("R10 refresh", 0, 0, 16'd0);
    // random
    void'($urandom(32'h1234));
    for (int blk = 0; blk < 12; blk++) begin
      wr(3'd0, 8'($urandom));
      wr(3'd3, 8'($urandom)); wr(3'd4, 8'($urandom));
      wr(3'd5, 8'($urandom_range(0, 3)));
      for (int k = 0; k < 40; k++) begin
        logic [15:0] v[3];
        for (int a = 0; a < 3; a++)
          v[a] = ($urandom_range(0, 1) == 1) ? 16'($urandom)
                 : 16'({m_thh, m_thl} + 16'($signed($urandom_range(0, 4)) - 2));
        smp("R8 random", v[0], v[1], v[2]);
        if ($urandom_range(0, 7) == 0) clr("R10 random clear");
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule